// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block is the control state machine that walks a device through a lifecycle-state change. When a request arrives while it is waiting, it runs a fixed series of steps. It switches the clock source, bumps and commits a transition counter, checks that the move is allowed, and hashes the supplied token. It then optionally erases flash for a return-for-analysis move, compares the token in two stages and finally writes the new state. Any step that fails drops the machine into a common finished state, which it leaves only on escalation.

Two redundant escalation inputs pull the machine into a locked escalation state from almost everywhere. An external illegal-encoding indication, or a corrupted state register, traps it in an invalid state. A scrap command seen while waiting parks it in a scrap state. Each working step raises one strobe and waits for a one-cycle acknowledge or error from the resource it drives. The surrounding hash engine, flash and non-volatile storage answer through these handshakes.

Top module: `lc_xfer_fsm`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises, the state is BOOT, `step_o` is 0 and `done_o`/`err_o` are 0. The next clock edge moves BOOT to WAIT.
- R2: `state_o` carries a 7-bit code. State index n (BOOT=1, WAIT=2, CLKSW=3, CNTINC=4, CNTWR=5, LEGAL=6, HASH=7, RMA=8, TOKA=9, TOKB=10, WRITE=11, DONE=12, SCRAP=13, ESC=14, BAD=15) is encoded as {n[3:0], n1^n2^n3, n0^n2^n3, n0^n1^n3}. Any two codes differ in at least 3 bits.
- R3: In WAIT the priority is escalation (to ESC), then `bad_enc_i` (to BAD), then `scrap_i` (to SCRAP), then `req_i` (to CLKSW). With none of these inputs high, the state stays WAIT.
- R4: CLKSW moves to CNTINC after exactly one cycle, whatever `ack_i` and `err_i` are.
- R5: CNTINC, CNTWR, LEGAL and HASH each hold until `ack_i` or `err_i` is high. `err_i` sends the machine to DONE and wins over `ack_i`. `ack_i` alone advances in the order CNTINC, CNTWR, LEGAL, HASH, RMA.
- R6: With `rma_i` high, RMA waits for `ack_i` or `err_i` and then goes to TOKA. With `rma_i` low, RMA goes to TOKA on the next edge and raises no strobe.
- R7: TOKA and TOKB each last one cycle. With `match_i` high, TOKA goes to TOKB and TOKB goes to WRITE. With `match_i` low, either one goes to DONE; TOKB never follows itself.
- R8: WRITE goes to DONE on `ack_i` or `err_i`. In DONE, `done_o` is 1. `err_o` is 0 only if WRITE ended with `ack_i` high and `err_i` low; otherwise it is 1.
- R9: DONE ignores `req_i`, `scrap_i`, handshakes and `bad_enc_i`, and leaves only on escalation.
- R10: Either `esc0_i` or `esc1_i` high moves every state except SCRAP to ESC on the next edge, including DONE and BAD. ESC is held until reset, and `err_o` is 1 there.
- R11: `bad_enc_i` high (without escalation) moves every state other than DONE, SCRAP, ESC and BAD to BAD. A state register holding a non-legal code also goes to BAD. BAD is held apart from escalation, and `err_o` is 1 there.
- R12: `step_o` is at most one-hot: bit0 CLKSW, bit1 CNTINC, bit2 CNTWR, bit3 LEGAL, bit4 HASH, bit5 RMA (only while `rma_i` is high), bit6 WRITE. It is 0 in every other state.
- R13: SCRAP is held until reset, ignores both escalation inputs, and shows `err_o` 0 and `done_o` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transition request |
| scrap_i | input | 1 | Direct scrap command |
| ack_i | input | 1 | Step completed acknowledge |
| err_i | input | 1 | Step error |
| rma_i | input | 1 | Transition needs the flash erase step |
| match_i | input | 1 | Token comparison result |
| esc0_i | input | 1 | Escalation input, first copy |
| esc1_i | input | 1 | Escalation input, second copy |
| bad_enc_i | input | 1 | External illegal-encoding indication |
| state_o | output | 7 | Current state code |
| step_o | output | 7 | One-hot step strobe |
| done_o | output | 1 | Sequencer is in DONE |
| err_o | output | 1 | Error or lock indication |

## Verification
The hardest situation to reach is a state register holding a code outside the legal set. No port can write such a code, and the sparse encoding keeps a single corruption from landing on a legal code. The stimulus therefore drives `bad_enc_i`, the external form of the same fault, in WAIT, in the middle of the sequence and in DONE. The internal trap is left to the legal-code property. Reaching late states such as TOKB and WRITE with a failure takes a full handshake walk, so directed tasks replay the acknowledge sequence before each corner case is injected.

// File: rtl/lc_xfer_fsm.sv
module lc_xfer_fsm (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       scrap_i,
  input  logic       ack_i,
  input  logic       err_i,
  input  logic       rma_i,
  input  logic       match_i,
  input  logic       esc0_i,
  input  logic       esc1_i,
  input  logic       bad_enc_i,
  output logic [6:0] state_o,
  output logic [6:0] step_o,
  output logic       done_o,
  output logic       err_o
);
  function automatic logic [6:0] cw(input logic [3:0] d);
    return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
  endfunction

  localparam logic [6:0] S_BOOT   = cw(4'd1);
  localparam logic [6:0] S_WAIT   = cw(4'd2);
  localparam logic [6:0] S_CLKSW  = cw(4'd3);
  localparam logic [6:0] S_CNTINC = cw(4'd4);
  localparam logic [6:0] S_CNTWR  = cw(4'd5);
  localparam logic [6:0] S_LEGAL  = cw(4'd6);
  localparam logic [6:0] S_HASH   = cw(4'd7);
  localparam logic [6:0] S_RMA    = cw(4'd8);
  localparam logic [6:0] S_TOKA   = cw(4'd9);
  localparam logic [6:0] S_TOKB   = cw(4'd10);
  localparam logic [6:0] S_WRITE  = cw(4'd11);
  localparam logic [6:0] S_DONE   = cw(4'd12);
  localparam logic [6:0] S_SCRAP  = cw(4'd13);
  localparam logic [6:0] S_ESC    = cw(4'd14);
  localparam logic [6:0] S_BAD    = cw(4'd15);

  logic [6:0] st_q, st_d;
  logic       ok_q;
  logic       esc;

  assign esc = esc0_i | esc1_i;

  always_comb begin
    st_d = st_q;
    if (esc && st_q != S_SCRAP) begin
      st_d = S_ESC;
    end else if (bad_enc_i && !(st_q inside {S_DONE, S_SCRAP, S_ESC, S_BAD})) begin
      st_d = S_BAD;
    end else begin
      case (st_q)
        S_BOOT:   st_d = S_WAIT;
        S_WAIT:   if (scrap_i) st_d = S_SCRAP;
                  else if (req_i) st_d = S_CLKSW;
        S_CLKSW:  st_d = S_CNTINC;
        S_CNTINC: if (err_i) st_d = S_DONE; else if (ack_i) st_d = S_CNTWR;
        S_CNTWR:  if (err_i) st_d = S_DONE; else if (ack_i) st_d = S_LEGAL;
        S_LEGAL:  if (err_i) st_d = S_DONE; else if (ack_i) st_d = S_HASH;
        S_HASH:   if (err_i) st_d = S_DONE; else if (ack_i) st_d = S_RMA;
        S_RMA:    if (!rma_i || ack_i || err_i) st_d = S_TOKA;
        S_TOKA:   st_d = match_i ? S_TOKB : S_DONE;
        S_TOKB:   st_d = match_i ? S_WRITE : S_DONE;
        S_WRITE:  if (ack_i || err_i) st_d = S_DONE;
        S_DONE, S_SCRAP, S_ESC, S_BAD: st_d = st_q;
        default:  st_d = S_BAD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_BOOT;
      ok_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == S_WRITE && ack_i && !err_i && !esc && !bad_enc_i) ok_q <= 1'b1;
    end
  end

  assign state_o = st_q;
  assign step_o  = {st_q == S_WRITE, st_q == S_RMA && rma_i, st_q == S_HASH,
                    st_q == S_LEGAL, st_q == S_CNTWR, st_q == S_CNTINC, st_q == S_CLKSW};
  assign done_o  = st_q == S_DONE;
  assign err_o   = (st_q == S_DONE && !ok_q) || st_q == S_ESC || st_q == S_BAD;
endmodule

// File: rtl/lc_xfer_fsm_chk.sv
module lc_xfer_fsm_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       esc0_i,
  input logic       esc1_i,
  input logic       bad_enc_i,
  input logic [6:0] state_o,
  input logic [6:0] step_o,
  input logic       done_o,
  input logic       err_o
);
  function automatic logic [6:0] cw(input logic [3:0] d);
    return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
  endfunction

  function automatic logic legal(input logic [6:0] s);
    logic hit;
    hit = 1'b0;
    for (int i = 1; i < 16; i++) if (s == cw(4'(i))) hit = 1'b1;
    return hit;
  endfunction

  AST_ESC_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (esc0_i || esc1_i) && state_o != cw(4'd13) |=> state_o == cw(4'd14)); // R10
  AST_ESC_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == cw(4'd14) |=> state_o == cw(4'd14)); // R10
  AST_SCRAP_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == cw(4'd13) |=> state_o == cw(4'd13)); // R13
  AST_LEGAL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal(state_o)); // R2
  AST_STEP_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step_o)); // R12
  AST_TOKB_NO_SELF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == cw(4'd10) |=> state_o != cw(4'd10)); // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == cw(4'd12) && !esc0_i && !esc1_i |=> state_o == cw(4'd12) && $stable(err_o)); // R9
  AST_CLKSW_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == cw(4'd3) && !esc0_i && !esc1_i && !bad_enc_i |=> state_o == cw(4'd4)); // R4
  AST_BAD_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_enc_i && !esc0_i && !esc1_i && state_o == cw(4'd2) |=> state_o == cw(4'd15)); // R11
  AST_DONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (state_o == cw(4'd12))); // R8
endmodule

bind lc_xfer_fsm lc_xfer_fsm_chk u_chk (.*);

// File: tb/test_lc_xfer_fsm.sv
`timescale 1ns/1ps
module test_lc_xfer_fsm;
  logic clk = 0, rst_ni = 0;
  logic req, scrap, ack, err, rma, match, esc0, esc1, bad;
  logic [6:0] state_o, step_o;
  logic done_o, err_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  lc_xfer_fsm i_lc_xfer_fsm (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .scrap_i(scrap), .ack_i(ack),
    .err_i(err), .rma_i(rma), .match_i(match), .esc0_i(esc0), .esc1_i(esc1),
    .bad_enc_i(bad), .state_o(state_o), .step_o(step_o), .done_o(done_o), .err_o(err_o));

  function automatic logic [6:0] cw(input logic [3:0] d);
    return {d, d[1]^d[2]^d[3], d[0]^d[2]^d[3], d[0]^d[1]^d[3]};
  endfunction

  localparam logic [8:0] I_REQ = 9'b100000000, I_SCR = 9'b010000000, I_ACK = 9'b001000000,
                         I_ERR = 9'b000100000, I_RMA = 9'b000010000, I_MAT = 9'b000001000,
                         I_E0  = 9'b000000100, I_E1  = 9'b000000010, I_BAD = 9'b000000001;

  localparam logic [12:0] VEC [16] = '{
    13'b000000000_0010, 13'b100000000_0011, 13'b000000000_0100, 13'b000000000_0100,
    13'b001000000_0101, 13'b001000000_0110, 13'b001000000_0111, 13'b001000000_1000,
    13'b000010000_1000, 13'b001010000_1001, 13'b000001000_1010, 13'b000001000_1011,
    13'b001000000_1100, 13'b100000000_1100, 13'b000000100_1110, 13'b000000000_1110};

  task automatic chk(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic go(logic [8:0] v);
    @(negedge clk);
    {req, scrap, ack, err, rma, match, esc0, esc1, bad} = v;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    {req, scrap, ack, err, rma, match, esc0, esc1, bad} = '0;
    rst_ni = 0;
    repeat (2) @(posedge clk);
    #1 rst_ni = 1;
  endtask

  task automatic to_hash();
    do_reset();
    go(0); go(I_REQ); go(0); go(I_ACK); go(I_ACK); go(I_ACK);
    chk("R5 reach HASH", state_o, cw(7));
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 R2 reset state", state_o, cw(1));
    chk("R1 reset step", step_o, 0);
    chk("R1 reset flags", {done_o, err_o}, 0);

    for (int i = 0; i < 16; i++) begin
      go(VEC[i][12:4]);
      chk($sformatf("R5 R6 R7 table row %0d", i), state_o, cw(VEC[i][3:0]));
      if (i == 8)  chk("R12 RMA strobe", step_o, 7'b0100000);
      if (i == 12) chk("R8 success flags", {done_o, err_o}, 2'b10);
      if (i == 13) chk("R9 done ignores req", state_o, cw(12));
      if (i == 15) chk("R10 esc err flag", err_o, 1);
    end

    do_reset();
    go(0); go(I_REQ);
    chk("R12 CLKSW strobe", step_o, 7'b0000001);
    go(I_ACK | I_ERR);
    chk("R4 CLKSW one cycle", state_o, cw(4));
    chk("R12 CNTINC strobe", step_o, 7'b0000010);
    go(0);
    chk("R5 waits for handshake", state_o, cw(4));
    go(I_ACK); go(I_ERR);
    chk("R5 error to DONE", state_o, cw(12));
    chk("R8 error flags", {done_o, err_o}, 2'b11);
    go(I_BAD | I_REQ);
    chk("R9 R11 DONE ignores bad", state_o, cw(12));
    go(I_E1);
    chk("R10 DONE to ESC", state_o, cw(14));

    do_reset();
    go(0); go(I_REQ); go(0); go(I_ACK); go(I_ACK);
    go(I_ACK | I_ERR);
    chk("R5 err wins over ack", state_o, cw(12));

    to_hash();
    chk("R12 HASH strobe", step_o, 7'b0010000);
    go(I_ACK);
    chk("R6 to RMA", state_o, cw(8));
    chk("R6 R12 no strobe without rma", step_o, 0);
    go(0);
    chk("R6 skip to TOKA", state_o, cw(9));
    go(0);
    chk("R7 TOKA mismatch", state_o, cw(12));

    to_hash();
    go(I_ACK); go(0); go(I_MAT);
    chk("R7 TOKA match", state_o, cw(10));
    go(0);
    chk("R7 TOKB mismatch exits", state_o, cw(12));

    to_hash();
    go(I_ACK); go(0); go(I_MAT); go(I_MAT);
    chk("R7 to WRITE", state_o, cw(11));
    chk("R12 WRITE strobe", step_o, 7'b1000000);
    go(I_ERR);
    chk("R8 WRITE error", {state_o, done_o, err_o}, {cw(12), 2'b11});

    to_hash();
    go(I_BAD);
    chk("R11 mid-flow bad", state_o, cw(15));
    chk("R11 bad err flag", err_o, 1);

    do_reset();
    go(0); go(I_SCR | I_REQ);
    chk("R3 scrap over req", state_o, cw(13));
    go(I_E0 | I_E1);
    chk("R13 scrap ignores esc", state_o, cw(13));
    chk("R13 scrap flags", {done_o, err_o}, 0);

    do_reset();
    go(0); go(I_BAD | I_SCR);
    chk("R3 bad over scrap", state_o, cw(15));
    go(I_REQ);
    chk("R11 BAD sticky", state_o, cw(15));
    go(I_E0);
    chk("R10 BAD to ESC", state_o, cw(14));

    do_reset();
    go(0); go(0);
    chk("R3 WAIT idle hold", state_o, cw(2));
    go(I_E1 | I_BAD);
    chk("R3 esc over bad", state_o, cw(14));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule